// File: doc/BRIEF.md
# UART Interrupt Prioritizer and Identifier

This block gathers the four interrupt causes of a character-mode UART into a single host interrupt. It also reports, through an identification register value, which enabled cause currently has the highest priority. The four causes are a receive line error, received data ready, transmit holding register empty and a modem status change. A four-bit enable register selects which causes may raise the interrupt. The host sees one interrupt output. That output is driven only while the modem control OUT2 gate is set.

Each cause is held in its own pending flag, and each flag has its own clear strobe. The register front end decodes host accesses into these strobes: line status read, receive buffer read, transmit holding write, modem status read and identification read. The line error, data ready and modem change causes arrive as one-cycle event pulses. Transmit holding empty arrives as a level. It arms on its rising edge, and it arms again when its enable bit is switched on while the holding register is already empty. A cause that is not enabled stays pending and shows as soon as it is enabled. Serialisation, FIFO mode and address decode are handled elsewhere.

Top module: `uirq_ident`

## Requirements
- R1: An enable-register write stores `ier_wdata[3:0]` from the next cycle on: bit 0 enables received data, bit 1 transmit empty, bit 2 line error, bit 3 modem change. `ier_rdata[7:4]` always reads 0, so a write of 0xFF reads back 0x0F.
- R2: `iir_rdata[0]` is 0 while at least one enabled cause is pending and 1 otherwise. `iir_rdata[7:4]` is always 0. With all four enable bits at 0, `iir_rdata` reads 0x01 whatever is pending.
- R3: `iir_rdata[3:1]` reports the highest enabled pending cause. The order, with codes, is: line error 011 (IIR 0x06), received data 010 (0x04), transmit empty 001 (0x02), modem change 000 (0x00).
- R4: A line status read clears the line error cause from the next cycle.
- R5: A receive buffer read clears the received data cause from the next cycle.
- R6: A transmit holding write clears the transmit empty cause from the next cycle.
- R7: An identification read clears the transmit empty cause only when it is the reported cause (IIR 0x02). When a higher cause is reported, the read leaves transmit empty pending.
- R8: Transmit empty becomes pending on a 0-to-1 change of `thr_empty`. It also becomes pending when an enable write turns bit 1 from 0 to 1 while `thr_empty` is 1. A write that leaves bit 1 already at 1 does not re-arm it.
- R9: A modem status read clears the modem change cause from the next cycle.
- R10: `irq_oe` equals `out2`. While `irq_oe` is 0, `irq` is 0 and the line counts as not driven. While `irq_oe` is 1, `irq` is 1 exactly when `iir_rdata[0]` is 0. After reset, `irq_oe` is 0, `iir_rdata` is 0x01 and `ier_rdata` is 0x00.
- R11: When a cause's event and its clear strobe occur in the same cycle, the cause is pending in the next cycle.
- R12: A cause that occurs while its enable bit is 0 stays pending. It is reported once the enable bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ier_wr | input | 1 | Enable register write strobe |
| ier_wdata | input | DW | Enable register write data |
| iir_rd | input | 1 | Identification register read strobe |
| lsr_rd | input | 1 | Line status register read strobe |
| rbr_rd | input | 1 | Receive buffer read strobe |
| thr_wr | input | 1 | Transmit holding register write strobe |
| msr_rd | input | 1 | Modem status register read strobe |
| out2 | input | 1 | Modem control OUT2 gate for the host interrupt |
| line_err_ev | input | 1 | Pulse: receive line error detected |
| rx_ready_ev | input | 1 | Pulse: character placed in the receive buffer |
| thr_empty | input | 1 | Level: transmit holding register is empty |
| modem_chg_ev | input | 1 | Pulse: a modem input changed |
| ier_rdata | output | DW | Enable register read value |
| iir_rdata | output | DW | Identification register read value |
| irq | output | 1 | Host interrupt level (valid while irq_oe is 1) |
| irq_oe | output | 1 | Host interrupt output enable |

## Verification
The bench first raises all causes in one cycle and then removes them one at a time with their own clear strobes. Each IIR step shows that the ordering is right and that each strobe clears only its own cause. Identification reads are issued both while transmit empty is reported and while a higher cause hides it, which separates the conditional clear from an unconditional one. Enable writes that turn bit 1 on and writes that leave it on show the re-arm edge, and same-cycle event/clear pairs pin down set priority. A long phase of pseudo-random strobes and events, compared every cycle against a behavioural model, covers the interactions between these paths.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
    localparam int NSRC      = 4;
    localparam int IDX_RX    = 0;
    localparam int IDX_THRE  = 1;
    localparam int IDX_LINE  = 2;
    localparam int IDX_MODEM = 3;
    localparam int ID_W      = 3;

    typedef enum logic [ID_W-1:0] {
        ID_MODEM = 3'b000,
        ID_THRE  = 3'b001,
        ID_RX    = 3'b010,
        ID_LINE  = 3'b011
    } irq_id_e;

    typedef struct packed {
        logic [NSRC-1:0] ier;
        logic            thr_prev;
    } ctl_t;
endpackage

// File: rtl/uirq_flag.sv
module uirq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic pend_o
);
    logic pend_d, pend_q;

    always_comb begin
        pend_d = pend_q;
        if (clr_i) pend_d = 1'b0;
        if (set_i) pend_d = 1'b1;   // a new event beats its own clear
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= pend_d;
    end

    assign pend_o = pend_q;
endmodule

// File: rtl/uirq_prio.sv
module uirq_prio
    import uirq_pkg::*;
(
    input  logic [NSRC-1:0] act_i,
    output irq_id_e         id_o,
    output logic            any_o
);
    always_comb begin
        any_o = |act_i;
        if (act_i[IDX_LINE])      id_o = ID_LINE;
        else if (act_i[IDX_RX])   id_o = ID_RX;
        else if (act_i[IDX_THRE]) id_o = ID_THRE;
        else                      id_o = ID_MODEM;
    end
endmodule

// File: rtl/uirq_ident.sv
module uirq_ident
    import uirq_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ier_wr,
    input  logic [DW-1:0] ier_wdata,
    input  logic          iir_rd,
    input  logic          lsr_rd,
    input  logic          rbr_rd,
    input  logic          thr_wr,
    input  logic          msr_rd,
    input  logic          out2,
    input  logic          line_err_ev,
    input  logic          rx_ready_ev,
    input  logic          thr_empty,
    input  logic          modem_chg_ev,
    output logic [DW-1:0] ier_rdata,
    output logic [DW-1:0] iir_rdata,
    output logic          irq,
    output logic          irq_oe
);
    localparam int PAD_IER = DW - NSRC;
    localparam int PAD_IIR = DW - ID_W - 1;

    ctl_t            ctl_d, ctl_q;
    logic [NSRC-1:0] set_v, clr_v, pend_v, act_v;
    irq_id_e         id;
    logic            any;

    always_comb begin
        ctl_d          = ctl_q;
        ctl_d.thr_prev = thr_empty;
        if (ier_wr) ctl_d.ier = ier_wdata[NSRC-1:0];

        set_v[IDX_LINE]  = line_err_ev;
        set_v[IDX_RX]    = rx_ready_ev;
        set_v[IDX_MODEM] = modem_chg_ev;
        set_v[IDX_THRE]  = (thr_empty & ~ctl_q.thr_prev)
                         | (ier_wr & ier_wdata[IDX_THRE] & ~ctl_q.ier[IDX_THRE] & thr_empty);

        clr_v[IDX_LINE]  = lsr_rd;
        clr_v[IDX_RX]    = rbr_rd;
        clr_v[IDX_MODEM] = msr_rd;
        clr_v[IDX_THRE]  = thr_wr | (iir_rd & any & (id == ID_THRE));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.ier      <= '0;
            ctl_q.thr_prev <= 1'b1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        uirq_flag u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (set_v[g]),
            .clr_i  (clr_v[g]),
            .pend_o (pend_v[g])
        );
    end

    assign act_v = pend_v & ctl_q.ier;

    uirq_prio u_prio (
        .act_i (act_v),
        .id_o  (id),
        .any_o (any)
    );

    assign ier_rdata = {{PAD_IER{1'b0}}, ctl_q.ier};
    assign iir_rdata = {{PAD_IIR{1'b0}}, id, ~any};
    assign irq_oe    = out2;
    assign irq       = out2 & any;
endmodule

// File: rtl/uirq_ident_chk.sv
module uirq_ident_chk
    import uirq_pkg::*;
#(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ier_wr,
    input logic [DW-1:0] ier_wdata,
    input logic          iir_rd,
    input logic          lsr_rd,
    input logic          rbr_rd,
    input logic          thr_wr,
    input logic          msr_rd,
    input logic          out2,
    input logic          line_err_ev,
    input logic          rx_ready_ev,
    input logic          thr_empty,
    input logic          modem_chg_ev,
    input logic [DW-1:0] ier_rdata,
    input logic [DW-1:0] iir_rdata,
    input logic          irq,
    input logic          irq_oe
);
    AST_IER_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ier_rdata[DW-1:NSRC] == '0); // R1
    AST_IER_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        ier_wr |=> ier_rdata[NSRC-1:0] == $past(ier_wdata[NSRC-1:0])); // R1
    AST_IIR_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        iir_rdata[DW-1:4] == '0); // R2
    AST_MASKED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ier_rdata[NSRC-1:0] == '0) |-> (iir_rdata == 8'h01)); // R2
    AST_LSR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (lsr_rd && !line_err_ev) |=> (iir_rdata[3:1] != 3'b011)); // R4
    AST_RBR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rbr_rd && !rx_ready_ev) |=> (iir_rdata[3:1] != 3'b010)); // R5
    AST_THR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_wr && !thr_empty) |=> (iir_rdata[3:1] != 3'b001)); // R6
    AST_MSR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (msr_rd && !modem_chg_ev) |=> (iir_rdata[3:0] != 4'b0000)); // R9
    AST_IRQ_TRACKS_IIR: assert property (@(posedge clk) disable iff (!rst_n)
        irq_oe |-> (irq == !iir_rdata[0])); // R10
    AST_IRQ_QUIET_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_oe |-> !irq); // R10
endmodule

bind uirq_ident uirq_ident_chk #(.DW(DW)) u_chk (.*);

// File: tb/uirq_ident_test.sv
module uirq_ident_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ier_wr = 0, iir_rd = 0, lsr_rd = 0, rbr_rd = 0, thr_wr = 0, msr_rd = 0;
    logic       out2 = 0, line_err_ev = 0, rx_ready_ev = 0, thr_empty = 1, modem_chg_ev = 0;
    logic [7:0] ier_wdata = 8'h00;
    logic [7:0] ier_rdata, iir_rdata;
    logic       irq, irq_oe;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // behavioural reference state
    bit [3:0] m_ier;
    bit m_line, m_rx, m_thre, m_modem, m_prev;

    always #5 clk = ~clk;

    uirq_ident uut (.*);

    function automatic logic [7:0] m_iir();
        if (m_line && m_ier[2])       return 8'h06;
        else if (m_rx && m_ier[0])    return 8'h04;
        else if (m_thre && m_ier[1])  return 8'h02;
        else if (m_modem && m_ier[3]) return 8'h00;
        return 8'h01;
    endfunction

    task automatic m_reset();
        m_ier = 0; m_line = 0; m_rx = 0; m_thre = 0; m_modem = 0; m_prev = 1;
    endtask

    task automatic m_update();
        logic [7:0] rep;
        bit t_set, t_clr;
        rep   = m_iir();
        t_set = (thr_empty && !m_prev) || (ier_wr && ier_wdata[1] && !m_ier[1] && thr_empty);
        t_clr = thr_wr || (iir_rd && rep == 8'h02);
        if (line_err_ev) m_line = 1; else if (lsr_rd) m_line = 0;
        if (rx_ready_ev) m_rx = 1; else if (rbr_rd) m_rx = 0;
        if (modem_chg_ev) m_modem = 1; else if (msr_rd) m_modem = 0;
        if (t_set) m_thre = 1; else if (t_clr) m_thre = 0;
        m_prev = thr_empty;
        if (ier_wr) m_ier = ier_wdata[3:0];
    endtask

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_model();
        logic [7:0] e;
        e = m_iir();
        check("MODEL iir", iir_rdata, e);
        check("MODEL ier", ier_rdata, {4'h0, m_ier});
        check("MODEL irq_oe", {7'h0, irq_oe}, {7'h0, out2});
        check("MODEL irq", {7'h0, irq}, {7'h0, out2 && e[0] == 1'b0});
    endtask

    task automatic step();
        @(posedge clk);
        m_update();
        @(negedge clk);
        compare_model();
        ier_wr = 0; iir_rd = 0; lsr_rd = 0; rbr_rd = 0; thr_wr = 0; msr_rd = 0;
        line_err_ev = 0; rx_ready_ev = 0; modem_chg_ev = 0;
    endtask

    task automatic wr_ier(logic [7:0] v);
        ier_wr = 1; ier_wdata = v; step();
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        m_reset();
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 reset iir", iir_rdata, 8'h01);
        check("R10 reset ier", ier_rdata, 8'h00);
        check("R10 reset oe", {7'h0, irq_oe}, 8'h00);
        rst_n = 1;
        step();

        // R1 upper bits read zero; enabling bit 1 while empty arms transmit empty (R8)
        wr_ier(8'hFF);
        check("R1 ier readback", ier_rdata, 8'h0F);
        check("R8 rearm on enable", iir_rdata, 8'h02);
        check("R10 undriven irq", {6'h0, irq_oe, irq}, 8'h00);
        out2 = 1; step();
        check("R10 driven irq", {6'h0, irq_oe, irq}, 8'h03);
        iir_rd = 1; step();
        check("R7 iir read clears reported thre", iir_rdata, 8'h01);

        // R3 priority, then per-cause clears
        line_err_ev = 1; rx_ready_ev = 1; modem_chg_ev = 1; step();
        check("R3 line highest", iir_rdata, 8'h06);
        lsr_rd = 1; step();
        check("R4 lsr read clears line", iir_rdata, 8'h04);
        thr_empty = 0; step();
        thr_empty = 1; step();
        check("R8 edge arms thre under rx", iir_rdata, 8'h04);
        iir_rd = 1; step();
        rbr_rd = 1; step();
        check("R7 hidden thre survives iir read", iir_rdata, 8'h02);
        check("R5 rbr read clears rx", iir_rdata, 8'h02);
        thr_wr = 1; thr_empty = 0; step();
        check("R6 thr write clears thre", iir_rdata, 8'h00);
        msr_rd = 1; step();
        check("R9 msr read clears modem", iir_rdata, 8'h01);

        // R11 event beats same-cycle clear
        rx_ready_ev = 1; rbr_rd = 1; step();
        check("R11 set wins", iir_rdata, 8'h04);
        rbr_rd = 1; step();
        check("R5 cleared after", iir_rdata, 8'h01);

        // R2 masking, R12 latent pending
        wr_ier(8'h00);
        line_err_ev = 1; step();
        check("R2 masked reads 01", iir_rdata, 8'h01);
        check("R2 masked no irq", {7'h0, irq}, 8'h00);
        wr_ier(8'h04);
        check("R12 latent line shows", iir_rdata, 8'h06);
        lsr_rd = 1; step();

        // R8 rearm only on 0->1 of enable bit
        thr_empty = 1; step();
        thr_wr = 1; step();
        wr_ier(8'h02);
        check("R8 rearm enable", iir_rdata, 8'h02);
        iir_rd = 1; step();
        wr_ier(8'h02);
        check("R8 no rearm when already on", iir_rdata, 8'h01);

        // R10 gate off with pending cause
        wr_ier(8'h08);
        modem_chg_ev = 1; out2 = 0; step();
        check("R10 pending but undriven", {6'h0, irq_oe, irq}, 8'h00);
        check("R3 modem code", iir_rdata, 8'h00);
        msr_rd = 1; step();

        // mixed traffic against the model
        for (int i = 0; i < 2000; i++) begin
            logic [31:0] r;
            r = $urandom;
            ier_wr = (r[3:0] == 0); ier_wdata = r[15:8];
            iir_rd = r[16]; lsr_rd = r[17] & r[18]; rbr_rd = r[19] & r[20];
            thr_wr = r[21] & r[22]; msr_rd = r[23] & r[24];
            line_err_ev = (r[27:25] == 0); rx_ready_ev = r[28] & r[29];
            modem_chg_ev = (r[31:29] == 0);
            if (r[4] & r[5]) thr_empty = ~thr_empty;
            out2 = r[6] | r[7];
            step();
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule